// File: doc/BRIEF.md
# Windowed Multichannel Hit Digitizer

This block time-stamps discriminator hits on a bank of channels (32 by default). It uses a fast sampling clock running at 44 times the beam-crossing rate, so each beam crossing splits into fine bins numbered 0 through 43. Each channel arrives as a single-bit level that is already synchronized to the fast clock. The block finds the rising edge of that level and tags it with the bin in which it was sampled. It then tests the bin against a lower and an upper limit that are set separately for every channel. Hits that pass go out as channel/bin records.

A mask bit for each channel removes that channel completely. A test-pulse source runs on the same sampling clock and can fire every channel at a programmable bin, so a scan that steps the pulse position should see the reported bin follow it. Hits that arrive together are held in a pending slot for each channel. They are drained lowest channel first into a small FIFO, and the FIFO feeds a valid/ready output stream. A sticky flag reports when the FIFO could not take a waiting record.

Top module: `hitwin_digitizer`

## Requirements
- R1: A pulse on `xing_start` makes `bin_now` read 0 on the following cycle. With no pulse, `bin_now` rises by one each cycle and goes from 43 back to 0.
- R2: A 0-to-1 change on a channel's effective input, sampled while `bin_now` equals b, produces a record whose `rec_bin` is b and whose `rec_chan` is the channel index.
- R3: Only the first rising edge on a channel within one crossing is recorded. A crossing ends when `bin_now` is 43 or when `xing_start` is pulsed. A level held high, even across a crossing boundary, gives no further record until it has returned low.
- R4: A hit is accepted only when lower <= bin <= upper, using that channel's limits: bits [6*ch+5:6*ch] of `win_lo` and `win_hi`. Both ends are inclusive. A lower limit greater than the upper limit accepts nothing.
- R5: A channel whose `mask` bit is 1 produces no record, whether the source is the discriminator or the test pulse.
- R6: While `tp_en` is 1, every channel sees a one-cycle rising input in the cycle where `bin_now` equals `tp_bin`. While `tp_en` is 0, the test pulse produces no record.
- R7: Records accepted in the same cycle leave in ascending channel order. No pending record is lost while the FIFO is full.
- R8: While `rec_valid` is 1 and `rec_ready` is 0, `rec_valid`, `rec_chan` and `rec_bin` stay unchanged.
- R9: `overflow` becomes 1 when a record waits while the FIFO is full, or when a new hit meets an occupied pending slot. Once set, it stays 1 until reset.
- R10: Reset leaves `bin_now` at 0, `rec_valid` at 0 and `overflow` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 44 times the crossing rate |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_start | input | 1 | Crossing-start strobe; the bin reads 0 on the next cycle |
| disc | input | NCH | Synchronized discriminator levels, one per channel |
| mask | input | NCH | 1 disables the channel |
| win_lo | input | NCH*6 | Lower bin limit for each channel, 6 bits per channel |
| win_hi | input | NCH*6 | Upper bin limit for each channel, 6 bits per channel |
| tp_en | input | 1 | Test pulse enable |
| tp_bin | input | 6 | Bin in which the test pulse fires |
| bin_now | output | 6 | Current fine bin |
| rec_valid | output | 1 | A record is presented |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_chan | output | 5 | Channel index of the record |
| rec_bin | output | 6 | Bin of the record |
| overflow | output | 1 | Sticky FIFO congestion or lost-hit flag |

## Verification
The assertions assume that `disc`, `mask`, the window limits and the test-pulse settings change only between clock edges. They also assume that a channel's limits do not change while that channel has a pending record, and that `tp_bin` stays below 44. The bench drives every input one time unit after the rising edge. It rewrites the windows and the mask only after each scenario has fully drained, and it only ever steps the test pulse to bins inside a crossing.

// File: rtl/hitwin_pkg.sv
package hitwin_pkg;
  localparam int unsigned NUM_CH   = 32;
  localparam int unsigned NUM_BINS = 44;
  localparam int unsigned BIN_W    = $clog2(NUM_BINS);

  // inclusive acceptance window test
  function automatic logic bin_in_window(input logic [BIN_W-1:0] b,
                                         input logic [BIN_W-1:0] lo,
                                         input logic [BIN_W-1:0] hi);
    return (lo <= b) && (b <= hi);
  endfunction

  // next fine bin: restart or wrap to 0, otherwise step by one
  function automatic logic [BIN_W-1:0] bin_advance(input logic [BIN_W-1:0] b,
                                                   input logic restart,
                                                   input logic [BIN_W-1:0] last);
    if (restart || b == last) return '0;
    return b + 1'b1;
  endfunction
endpackage

// File: rtl/hitwin_bin_ctr.sv
module hitwin_bin_ctr
  import hitwin_pkg::*;
#(
  parameter int unsigned NBINS = NUM_BINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xing_start,
  output logic [BIN_W-1:0] bin,
  output logic             xing_last
);
  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NBINS - 1);

  assign xing_last = xing_start || (bin == LAST_BIN);

  always_ff @(posedge clk) begin
    if (!rst_n) bin <= '0;
    else        bin <= bin_advance(bin, xing_start, LAST_BIN);
  end
endmodule

// File: rtl/hitwin_chan_bank.sv
module hitwin_chan_bank
  import hitwin_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       src,
  input  logic [NCH-1:0]       mask,
  input  logic [NCH*BIN_W-1:0] lo_flat,
  input  logic [NCH*BIN_W-1:0] hi_flat,
  input  logic [BIN_W-1:0]     bin,
  input  logic                 xing_last,
  input  logic [NCH-1:0]       grant,
  output logic [NCH-1:0]       pend,
  output logic [NCH*BIN_W-1:0] pend_bin,
  output logic [NCH-1:0]       accept,
  output logic                 lost
);
  logic [NCH-1:0] clash;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic prev_lvl;
    logic seen;
    logic rise_seen;

    assign rise_seen = src[g] & ~prev_lvl;
    assign accept[g] = rise_seen & ~seen & ~mask[g] &
                       bin_in_window(bin, lo_flat[g*BIN_W +: BIN_W], hi_flat[g*BIN_W +: BIN_W]);
    assign clash[g]  = accept[g] & pend[g] & ~grant[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_lvl                  <= 1'b0;
        seen                      <= 1'b0;
        pend[g]                   <= 1'b0;
        pend_bin[g*BIN_W +: BIN_W] <= '0;
      end else begin
        prev_lvl <= src[g];
        if (xing_last)      seen <= 1'b0;
        else if (rise_seen) seen <= 1'b1;
        if (accept[g] && !clash[g]) begin
          pend[g]                    <= 1'b1;
          pend_bin[g*BIN_W +: BIN_W] <= bin;
        end else if (grant[g]) begin
          pend[g] <= 1'b0;
        end
      end
    end
  end

  assign lost = |clash;
endmodule

// File: rtl/hitwin_pick.sv
module hitwin_pick #(
  parameter int unsigned NCH   = 32,
  localparam int unsigned IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req,
  input  logic             en,
  output logic [NCH-1:0]   grant,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && !found) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    if (en && found) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/hitwin_fifo.sv
module hitwin_fifo #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         not_empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          do_wr, do_rd;

  assign full      = (count == (AW+1)'(DEPTH));
  assign not_empty = (count != '0);
  assign do_wr     = wr_en && !full;
  assign do_rd     = rd_en && not_empty;
  assign rd_data   = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end
endmodule

// File: rtl/hitwin_digitizer.sv
module hitwin_digitizer
  import hitwin_pkg::*;
#(
  parameter int unsigned NCH        = NUM_CH,
  parameter int unsigned NBINS      = NUM_BINS,
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW        = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xing_start,
  input  logic [NCH-1:0]       disc,
  input  logic [NCH-1:0]       mask,
  input  logic [NCH*BIN_W-1:0] win_lo,
  input  logic [NCH*BIN_W-1:0] win_hi,
  input  logic                 tp_en,
  input  logic [BIN_W-1:0]     tp_bin,
  output logic [BIN_W-1:0]     bin_now,
  output logic                 rec_valid,
  input  logic                 rec_ready,
  output logic [CW-1:0]        rec_chan,
  output logic [BIN_W-1:0]     rec_bin,
  output logic                 overflow
);
  localparam int unsigned REC_W = CW + BIN_W;

  logic                 xing_last;
  logic                 tp_fire;
  logic [NCH-1:0]       src;
  logic [NCH-1:0]       pend, accept, grant;
  logic [NCH*BIN_W-1:0] pend_bin;
  logic                 lost;
  logic [CW-1:0]        pick_idx;
  logic                 fifo_full, fifo_wr;
  logic [REC_W-1:0]     wr_rec, rd_rec;

  hitwin_bin_ctr #(.NBINS(NBINS)) u_bins (
    .clk(clk), .rst_n(rst_n), .xing_start(xing_start),
    .bin(bin_now), .xing_last(xing_last)
  );

  assign tp_fire = tp_en && (bin_now == tp_bin);
  assign src     = disc | {NCH{tp_fire}};

  hitwin_chan_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .src(src), .mask(mask),
    .lo_flat(win_lo), .hi_flat(win_hi), .bin(bin_now), .xing_last(xing_last),
    .grant(grant), .pend(pend), .pend_bin(pend_bin), .accept(accept), .lost(lost)
  );

  hitwin_pick #(.NCH(NCH)) u_pick (
    .req(pend), .en(!fifo_full), .grant(grant), .idx(pick_idx)
  );

  assign fifo_wr = |grant;
  assign wr_rec  = {pick_idx, pend_bin[pick_idx*BIN_W +: BIN_W]};

  hitwin_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr), .wr_data(wr_rec), .full(fifo_full),
    .rd_en(rec_ready), .rd_data(rd_rec), .not_empty(rec_valid)
  );

  assign rec_chan = rd_rec[REC_W-1 -: CW];
  assign rec_bin  = rd_rec[BIN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else if (lost || (|pend && fifo_full)) overflow <= 1'b1;
  end
endmodule

// File: rtl/hitwin_checker.sv
module hitwin_checker
  import hitwin_pkg::*;
#(
  parameter int unsigned NCH   = NUM_CH,
  parameter int unsigned NBINS = NUM_BINS,
  localparam int unsigned CW   = $clog2(NCH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xing_start,
  input logic [BIN_W-1:0] bin_now,
  input logic             rec_valid,
  input logic             rec_ready,
  input logic [CW-1:0]    rec_chan,
  input logic [BIN_W-1:0] rec_bin,
  input logic             overflow,
  input logic [NCH-1:0]   grant,
  input logic             fifo_full,
  input logic             fifo_wr
);
  p_bin_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bin_now < BIN_W'(NBINS));
  p_bin_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xing_start |=> bin_now == '0);
  p_bin_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!xing_start && bin_now != BIN_W'(NBINS-1)) |=> bin_now == BIN_W'($past(bin_now) + 1'b1));
  p_rec_bin_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_bin < BIN_W'(NBINS));
  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> rec_valid && $stable(rec_chan) && $stable(rec_bin));
  p_no_write_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind hitwin_digitizer hitwin_checker #(.NCH(NCH), .NBINS(NBINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .xing_start(xing_start), .bin_now(bin_now),
  .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_chan(rec_chan), .rec_bin(rec_bin),
  .overflow(overflow), .grant(grant), .fifo_full(fifo_full), .fifo_wr(fifo_wr)
);

// File: tb/hitwin_digitizer_tb.sv
module hitwin_digitizer_tb;
  localparam int NCH = 32;
  localparam int BW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xing_start = 1'b0;
  logic [NCH-1:0] disc = '0;
  logic [NCH-1:0] mask = '0;
  logic [NCH*BW-1:0] win_lo = '0;
  logic [NCH*BW-1:0] win_hi = '0;
  logic tp_en = 1'b0;
  logic [BW-1:0] tp_bin = '0;
  logic [BW-1:0] bin_now;
  logic rec_valid;
  logic rec_ready = 1'b1;
  logic [4:0] rec_chan;
  logic [BW-1:0] rec_bin;
  logic overflow;

  int checks = 0;
  int errors = 0;
  int n_rec = 0;
  logic [4:0]    got_ch  [64];
  logic [BW-1:0] got_bin [64];

  always #2 clk = ~clk;

  hitwin_digitizer u_dut (
    .clk(clk), .rst_n(rst_n), .xing_start(xing_start), .disc(disc), .mask(mask),
    .win_lo(win_lo), .win_hi(win_hi), .tp_en(tp_en), .tp_bin(tp_bin),
    .bin_now(bin_now), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_chan(rec_chan), .rec_bin(rec_bin), .overflow(overflow)
  );

  // collect transfers away from the active edge
  always @(negedge clk) begin
    if (rst_n && rec_valid && rec_ready && n_rec < 64) begin
      got_ch[n_rec]  = rec_chan;
      got_bin[n_rec] = rec_bin;
      n_rec = n_rec + 1;
    end
  end

  // {chan[4:0], rise_bin[5:0], lo[5:0], hi[5:0], masked, expect_record}
  localparam int NVEC = 9;
  localparam logic [24:0] VEC [NVEC] = '{
    {5'd3,  6'd10, 6'd0,  6'd43, 1'b0, 1'b1},
    {5'd17, 6'd20, 6'd20, 6'd20, 1'b0, 1'b1},
    {5'd17, 6'd19, 6'd20, 6'd25, 1'b0, 1'b0},
    {5'd31, 6'd26, 6'd20, 6'd25, 1'b0, 1'b0},
    {5'd0,  6'd0,  6'd0,  6'd5,  1'b0, 1'b1},
    {5'd8,  6'd43, 6'd40, 6'd43, 1'b0, 1'b1},
    {5'd12, 6'd15, 6'd30, 6'd10, 1'b0, 1'b0},
    {5'd5,  6'd15, 6'd0,  6'd43, 1'b1, 1'b0},
    {5'd22, 6'd33, 6'd33, 6'd40, 1'b0, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_all();
    for (int c = 0; c < NCH; c++) begin
      win_lo[c*BW +: BW] = 6'd0;
      win_hi[c*BW +: BW] = 6'd43;
    end
    mask = '0;
  endtask

  // after this, bin_now reads 0
  task automatic begin_xing();
    xing_start = 1'b1;
    tick();
    xing_start = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    open_all();
    repeat (3) tick();
    // R10: reset state
    check(bin_now == 0, "R10 bin", int'(bin_now), 0);
    check(rec_valid == 0, "R10 valid", int'(rec_valid), 0);
    check(overflow == 0, "R10 overflow", int'(overflow), 0);
    rst_n = 1'b1;
    tick();

    // R1: restart, count, wrap
    begin_xing();
    check(bin_now == 0, "R1 restart", int'(bin_now), 0);
    repeat (43) tick();
    check(bin_now == 43, "R1 top bin", int'(bin_now), 43);
    tick();
    check(bin_now == 0, "R1 wrap", int'(bin_now), 0);
    repeat (5) tick();
    begin_xing();
    check(bin_now == 0, "R1 mid-crossing restart", int'(bin_now), 0);

    // R2 R4 R5: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] ch;
      logic [5:0] rb;
      ch = VEC[v][24:20];
      rb = VEC[v][19:14];
      open_all();
      win_lo[ch*BW +: BW] = VEC[v][13:8];
      win_hi[ch*BW +: BW] = VEC[v][7:2];
      mask[ch] = VEC[v][1];
      n_rec = 0;
      begin_xing();
      repeat (int'(rb)) tick();
      disc[ch] = 1'b1;
      repeat (3) tick();
      disc[ch] = 1'b0;
      repeat (50) tick();
      check(n_rec == int'(VEC[v][0]), "R2/R4/R5 record count", n_rec, int'(VEC[v][0]));
      if (VEC[v][0] && n_rec > 0) begin
        check(got_ch[0] == ch, "R2 channel", int'(got_ch[0]), int'(ch));
        check(got_bin[0] == rb, "R2 bin", int'(got_bin[0]), int'(rb));
      end
    end
    open_all();

    // R3: second edge in the same crossing is ignored, a later crossing records again
    n_rec = 0;
    begin_xing();
    repeat (5) tick();
    disc[9] = 1'b1;
    repeat (2) tick();
    disc[9] = 1'b0;
    repeat (3) tick();
    disc[9] = 1'b1;
    tick();
    disc[9] = 1'b0;
    repeat (40) tick();
    check(n_rec == 1, "R3 one per crossing", n_rec, 1);
    check(got_bin[0] == 5, "R3 first edge kept", int'(got_bin[0]), 5);
    n_rec = 0;
    begin_xing();
    repeat (3) tick();
    disc[9] = 1'b1;
    repeat (100) tick();
    disc[9] = 1'b0;
    repeat (10) tick();
    check(n_rec == 1, "R3 held level crosses boundary", n_rec, 1);
    check(got_bin[0] == 3, "R3 new crossing bin", int'(got_bin[0]), 3);

    // R6 R7: test pulse scan at two bins
    for (int s = 0; s < 2; s++) begin
      logic [5:0] pb;
      pb = (s == 0) ? 6'd7 : 6'd30;
      n_rec = 0;
      tp_bin = pb;
      begin_xing();
      tp_en = 1'b1;
      repeat (int'(pb) + 2) tick();
      tp_en = 1'b0;
      repeat (50) tick();
      check(n_rec == 32, "R6 all channels fire", n_rec, 32);
      for (int i = 0; i < 32 && i < n_rec; i++) begin
        check(got_ch[i] == 5'(i), "R7 ascending channel", int'(got_ch[i]), i);
        check(got_bin[i] == pb, "R6 bin follows pulse", int'(got_bin[i]), int'(pb));
      end
    end
    // R6: disabled pulse, plus R5 mask on pulse source
    n_rec = 0;
    begin_xing();
    repeat (50) tick();
    check(n_rec == 0, "R6 disabled", n_rec, 0);
    mask = 32'hFFFF_FFFE;
    tp_bin = 6'd4;
    begin_xing();
    tp_en = 1'b1;
    repeat (6) tick();
    tp_en = 1'b0;
    repeat (40) tick();
    check(n_rec == 1 && got_ch[0] == 0, "R5 mask on pulse", n_rec, 1);
    open_all();
    check(overflow == 0, "R9 clear before stall", int'(overflow), 0);

    // R8 R9 R7: stall, fill, then drain without loss
    n_rec = 0;
    rec_ready = 1'b0;
    tp_bin = 6'd12;
    begin_xing();
    tp_en = 1'b1;
    repeat (14) tick();
    tp_en = 1'b0;
    repeat (4) tick();
    check(rec_valid == 1 && rec_chan == 0, "R8 stalled head", int'(rec_chan), 0);
    repeat (30) tick();
    check(rec_valid == 1 && rec_chan == 0 && rec_bin == 12, "R8 head stable", int'(rec_bin), 12);
    check(overflow == 1, "R9 set when full", int'(overflow), 1);
    rec_ready = 1'b1;
    repeat (60) tick();
    check(n_rec == 32, "R7 no loss after stall", n_rec, 32);
    for (int i = 0; i < 32 && i < n_rec; i++)
      check(got_ch[i] == 5'(i), "R7 order after stall", int'(got_ch[i]), i);
    check(overflow == 1, "R9 sticky", int'(overflow), 1);

    summary();
  end
endmodule